// File: doc/BRIEF.md
# Dual-Port Semaphore Flag Bank

This block holds eight hardware lock flags shared by two independent ports, called left and right. Either port can claim a flag, give it back, or look at it through a dedicated semaphore path that sits beside, not inside, any memory array. It is meant for two agents that must agree on who owns a shared resource without any software arbitration protocol. The two agents have equal standing, except that the left side wins a true tie.

Each port uses an active-low semaphore select. It also uses a memory chip enable, which must be inactive for a semaphore access to count. A read/write strobe commits a write on its rising edge and selects a read while high. An active-low output enable, a 3-bit flag index, a single write data bit and two active-low lane enables complete the port. A port that writes 0 asks for a flag. If the other side already owns the flag, the request is held as pending. It turns into ownership as soon as the owner writes 1 to let go. A read returns 0 to the owner and 1 to everyone else, and the value is replicated across two 9-bit lanes.

Top module: `sem_bank_top`

## Requirements
- R1: After a synchronous active-high reset every flag is free, so both ports read 1 on all eight flags.
- R2: A write commits only in the cycle where read/write is high after being low in the previous cycle, with select low and chip enable high. Holding read/write high commits nothing more.
- R3: With select low and chip enable low at once, no flag changes and neither lane is driven.
- R4: Writing 0 to a free flag makes the writer its owner, so the owner reads 0 and the other port reads 1.
- R5: Writing 0 to a flag the other port owns leaves ownership unchanged and records a pending request, so the requester keeps reading 1.
- R6: When the owner writes 1, the flag is released. A pending request from the other port is granted at that same clock edge, and that port reads 0 from the next cycle on.
- R7: When both ports write 0 to the same free flag at the same edge, the left port becomes owner and the right request stays pending.
- R8: A read requires select low, chip enable high, read/write high and output enable low. Lane 0 is driven when lane enable bit 0 is low, and lane 1 when bit 1 is low. A driven lane carries the status bit in all 9 bits, and its bit in the lane-valid output is 1. An undriven lane carries zeros and has its valid bit at 0.
- R9: The flag index (3 bits) selects one of eight independent flags, and an access to one flag never changes another.
- R10: A port that writes 1 while only holding a pending request withdraws that request. The flag then becomes free when the owner releases it.
- R11: With select high, read/write edges commit nothing and no lane is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lt_sel_n | input | 1 | Left semaphore select, active low |
| lt_mem_en_n | input | 1 | Left memory chip enable, active low (must be high for semaphore access) |
| lt_rw | input | 1 | Left read (high) / write strobe (rising edge commits) |
| lt_oe_n | input | 1 | Left output enable, active low |
| lt_addr | input | 3 | Left flag index |
| lt_wbit | input | 1 | Left write data (0 request, 1 release) |
| lt_be_n | input | 2 | Left lane enables, active low (bit 0 lane 0, bit 1 lane 1) |
| lt_q_lo | output | 9 | Left lane 0 status |
| lt_q_hi | output | 9 | Left lane 1 status |
| lt_q_en | output | 2 | Left lane driven flags |
| rt_sel_n | input | 1 | Right semaphore select, active low |
| rt_mem_en_n | input | 1 | Right memory chip enable, active low |
| rt_rw | input | 1 | Right read / write strobe |
| rt_oe_n | input | 1 | Right output enable, active low |
| rt_addr | input | 3 | Right flag index |
| rt_wbit | input | 1 | Right write data |
| rt_be_n | input | 2 | Right lane enables, active low |
| rt_q_lo | output | 9 | Right lane 0 status |
| rt_q_hi | output | 9 | Right lane 1 status |
| rt_q_en | output | 2 | Right lane driven flags |

## Verification
Two kinds of work can land on one flag at the same edge. In the first, both ports request the same free flag. In the second, the owner releases while the other side has a request waiting. The bench provokes the first by raising both read/write strobes in the same cycle on every flag. It provokes the second by releasing a flag that holds a pending request. In both cases it judges the outcome from what each port reads back in the following cycles. The checker adds properties that look one edge ahead for the left win and for the immediate handoff.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;

  typedef struct packed {
    logic own_l;
    logic own_r;
    logic pend_l;
    logic pend_r;
  } flag_state_t;

  localparam flag_state_t FLAG_FREE = '0;

  // Rising edge of the strobe measured against its registered copy.
  function automatic logic strobe_rise(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

  // Read value seen by a port: 0 for the owner, 1 otherwise.
  function automatic logic seen_status(input logic owns);
    return ~owns;
  endfunction

  // One flag's next state from the releases and requests of this edge.
  function automatic flag_state_t flag_step(input flag_state_t cur,
                                            input logic l_req, input logic l_rel,
                                            input logic r_req, input logic r_rel);
    flag_state_t nx;
    logic l_want;
    logic r_want;
    nx.own_l = cur.own_l & ~l_rel;
    nx.own_r = cur.own_r & ~r_rel;
    l_want   = (cur.pend_l | l_req) & ~l_rel & ~nx.own_l;
    r_want   = (cur.pend_r | r_req) & ~r_rel & ~nx.own_r;
    if (!nx.own_l && !nx.own_r && l_want) begin
      nx.own_l = 1'b1;
      l_want   = 1'b0;
    end else if (!nx.own_l && !nx.own_r && r_want) begin
      nx.own_r = 1'b1;
      r_want   = 1'b0;
    end
    nx.pend_l = l_want;
    nx.pend_r = r_want;
    return nx;
  endfunction

endpackage

// File: rtl/sem_bank_front.sv
module sem_bank_front #(
  parameter int NFLAG = 8,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n,
  input  logic             mem_en_n,
  input  logic             rw,
  input  logic             oe_n,
  input  logic [AW-1:0]    addr,
  input  logic             wbit,
  output logic             commit,
  output logic             rd_ok,
  output logic [NFLAG-1:0] req_vec,
  output logic [NFLAG-1:0] rel_vec
);
  import sem_bank_pkg::*;

  logic rw_q;
  logic access;

  // Reset to high so a strobe held high out of reset is not an edge.
  always_ff @(posedge clk) begin
    if (rst) rw_q <= 1'b1;
    else     rw_q <= rw;
  end

  assign access = ~sel_n & mem_en_n;
  assign commit = access & strobe_rise(rw, rw_q);
  assign rd_ok  = access & rw & ~oe_n;

  for (genvar i = 0; i < NFLAG; i++) begin : g_dec
    logic hit;
    assign hit        = (addr == AW'(i));
    assign req_vec[i] = commit & hit & ~wbit;
    assign rel_vec[i] = commit & hit & wbit;
  end

endmodule

// File: rtl/sem_bank_cell.sv
module sem_bank_cell (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      l_req,
  input  logic                      l_rel,
  input  logic                      r_req,
  input  logic                      r_rel,
  output sem_bank_pkg::flag_state_t st
);
  import sem_bank_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) st <= FLAG_FREE;
    else     st <= flag_step(st, l_req, l_rel, r_req, r_rel);
  end

endmodule

// File: rtl/sem_bank_lanes.sv
module sem_bank_lanes #(
  parameter int NFLAG  = 8,
  parameter int AW     = 3,
  parameter int LANE_W = 9
) (
  input  logic              rd_ok,
  input  logic [AW-1:0]     addr,
  input  logic [NFLAG-1:0]  own_vec,
  input  logic [1:0]        be_n,
  output logic [LANE_W-1:0] q_lo,
  output logic [LANE_W-1:0] q_hi,
  output logic [1:0]        q_en
);
  import sem_bank_pkg::*;

  logic status;

  assign status = seen_status(own_vec[addr]);
  assign q_en   = {2{rd_ok}} & ~be_n;
  assign q_lo   = q_en[0] ? {LANE_W{status}} : '0;
  assign q_hi   = q_en[1] ? {LANE_W{status}} : '0;

endmodule

// File: rtl/sem_bank_top.sv
module sem_bank_top #(
  parameter int NFLAG  = 8,
  parameter int AW     = 3,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lt_sel_n,
  input  logic              lt_mem_en_n,
  input  logic              lt_rw,
  input  logic              lt_oe_n,
  input  logic [AW-1:0]     lt_addr,
  input  logic              lt_wbit,
  input  logic [1:0]        lt_be_n,
  output logic [LANE_W-1:0] lt_q_lo,
  output logic [LANE_W-1:0] lt_q_hi,
  output logic [1:0]        lt_q_en,
  input  logic              rt_sel_n,
  input  logic              rt_mem_en_n,
  input  logic              rt_rw,
  input  logic              rt_oe_n,
  input  logic [AW-1:0]     rt_addr,
  input  logic              rt_wbit,
  input  logic [1:0]        rt_be_n,
  output logic [LANE_W-1:0] rt_q_lo,
  output logic [LANE_W-1:0] rt_q_hi,
  output logic [1:0]        rt_q_en
);
  import sem_bank_pkg::*;

  // Index 0 is the left port, index 1 the right port.
  logic [1:0]       port_commit;
  logic [1:0]       port_rd_ok;
  logic [NFLAG-1:0] l_req_vec, l_rel_vec, r_req_vec, r_rel_vec;
  logic [NFLAG-1:0] own_l_vec, own_r_vec, pend_l_vec, pend_r_vec;

  sem_bank_front #(.NFLAG(NFLAG), .AW(AW)) u_front_lt (
    .clk(clk), .rst(rst), .sel_n(lt_sel_n), .mem_en_n(lt_mem_en_n),
    .rw(lt_rw), .oe_n(lt_oe_n), .addr(lt_addr), .wbit(lt_wbit),
    .commit(port_commit[0]), .rd_ok(port_rd_ok[0]),
    .req_vec(l_req_vec), .rel_vec(l_rel_vec)
  );

  sem_bank_front #(.NFLAG(NFLAG), .AW(AW)) u_front_rt (
    .clk(clk), .rst(rst), .sel_n(rt_sel_n), .mem_en_n(rt_mem_en_n),
    .rw(rt_rw), .oe_n(rt_oe_n), .addr(rt_addr), .wbit(rt_wbit),
    .commit(port_commit[1]), .rd_ok(port_rd_ok[1]),
    .req_vec(r_req_vec), .rel_vec(r_rel_vec)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    flag_state_t st;
    sem_bank_cell u_cell (
      .clk(clk), .rst(rst),
      .l_req(l_req_vec[i]), .l_rel(l_rel_vec[i]),
      .r_req(r_req_vec[i]), .r_rel(r_rel_vec[i]),
      .st(st)
    );
    assign own_l_vec[i]  = st.own_l;
    assign own_r_vec[i]  = st.own_r;
    assign pend_l_vec[i] = st.pend_l;
    assign pend_r_vec[i] = st.pend_r;
  end

  sem_bank_lanes #(.NFLAG(NFLAG), .AW(AW), .LANE_W(LANE_W)) u_lanes_lt (
    .rd_ok(port_rd_ok[0]), .addr(lt_addr), .own_vec(own_l_vec), .be_n(lt_be_n),
    .q_lo(lt_q_lo), .q_hi(lt_q_hi), .q_en(lt_q_en)
  );

  sem_bank_lanes #(.NFLAG(NFLAG), .AW(AW), .LANE_W(LANE_W)) u_lanes_rt (
    .rd_ok(port_rd_ok[1]), .addr(rt_addr), .own_vec(own_r_vec), .be_n(rt_be_n),
    .q_lo(rt_q_lo), .q_hi(rt_q_hi), .q_en(rt_q_en)
  );

endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int NFLAG = 8,
  parameter int AW    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             lt_sel_n,
  input logic             lt_mem_en_n,
  input logic             lt_rw,
  input logic             lt_oe_n,
  input logic [1:0]       lt_be_n,
  input logic [1:0]       lt_q_en,
  input logic [AW-1:0]    lt_addr,
  input logic [AW-1:0]    rt_addr,
  input logic             lt_wbit,
  input logic             rt_wbit,
  input logic [1:0]       port_commit,
  input logic [NFLAG-1:0] own_l_vec,
  input logic [NFLAG-1:0] own_r_vec,
  input logic [NFLAG-1:0] pend_l_vec,
  input logic [NFLAG-1:0] pend_r_vec
);

  // R4 / R5: a flag never has two owners.
  a_r4_single_owner: assert property (@(posedge clk) disable iff (rst)
    (own_l_vec & own_r_vec) == '0);

  // R3: an illegal left access changes no ownership when the right side is quiet.
  a_r3_illegal_hold: assert property (@(posedge clk) disable iff (rst)
    (!lt_sel_n && !lt_mem_en_n && !port_commit[1])
    |=> ($stable(own_l_vec) && $stable(own_r_vec)));

  // R7: tie on a free flag goes to the left, right stays pending.
  a_r7_left_wins_tie: assert property (@(posedge clk) disable iff (rst)
    (port_commit == 2'b11 && !lt_wbit && !rt_wbit && lt_addr == rt_addr &&
     !own_l_vec[lt_addr] && !own_r_vec[lt_addr])
    |=> (own_l_vec[$past(lt_addr)] && pend_r_vec[$past(lt_addr)]));

  // R6: right release hands a pending left request over at once.
  a_r6_handoff: assert property (@(posedge clk) disable iff (rst)
    (port_commit == 2'b10 && rt_wbit && own_r_vec[rt_addr] && pend_l_vec[rt_addr])
    |=> own_l_vec[$past(rt_addr)]);

  // R8: a lane is driven only on a legal read with its own enable low.
  a_r8_lane_gate: assert property (@(posedge clk) disable iff (rst)
    (lt_q_en != 2'b00)
    |-> (!lt_sel_n && lt_mem_en_n && lt_rw && !lt_oe_n && ((lt_q_en & lt_be_n) == 2'b00)));

endmodule

bind sem_bank_top sem_bank_chk #(.NFLAG(NFLAG), .AW(AW)) u_chk (
  .clk(clk), .rst(rst),
  .lt_sel_n(lt_sel_n), .lt_mem_en_n(lt_mem_en_n), .lt_rw(lt_rw), .lt_oe_n(lt_oe_n),
  .lt_be_n(lt_be_n), .lt_q_en(lt_q_en), .lt_addr(lt_addr), .rt_addr(rt_addr),
  .lt_wbit(lt_wbit), .rt_wbit(rt_wbit), .port_commit(port_commit),
  .own_l_vec(own_l_vec), .own_r_vec(own_r_vec),
  .pend_l_vec(pend_l_vec), .pend_r_vec(pend_r_vec)
);

// File: tb/tb_sem_bank_top.sv
module tb_sem_bank_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       lt_sel_n, lt_mem_en_n, lt_rw, lt_oe_n, lt_wbit;
  logic [2:0] lt_addr;
  logic [1:0] lt_be_n, lt_q_en;
  logic [8:0] lt_q_lo, lt_q_hi;
  logic       rt_sel_n, rt_mem_en_n, rt_rw, rt_oe_n, rt_wbit;
  logic [2:0] rt_addr;
  logic [1:0] rt_be_n, rt_q_en;
  logic [8:0] rt_q_lo, rt_q_hi;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  sem_bank_top dut (
    .clk(clk), .rst(rst),
    .lt_sel_n(lt_sel_n), .lt_mem_en_n(lt_mem_en_n), .lt_rw(lt_rw), .lt_oe_n(lt_oe_n),
    .lt_addr(lt_addr), .lt_wbit(lt_wbit), .lt_be_n(lt_be_n),
    .lt_q_lo(lt_q_lo), .lt_q_hi(lt_q_hi), .lt_q_en(lt_q_en),
    .rt_sel_n(rt_sel_n), .rt_mem_en_n(rt_mem_en_n), .rt_rw(rt_rw), .rt_oe_n(rt_oe_n),
    .rt_addr(rt_addr), .rt_wbit(rt_wbit), .rt_be_n(rt_be_n),
    .rt_q_lo(rt_q_lo), .rt_q_hi(rt_q_hi), .rt_q_en(rt_q_en)
  );

  task automatic check(input string tag, input logic [19:0] got, input logic [19:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Both ports may raise their strobe at the same edge.
  task automatic wr2(input logic le, input logic [2:0] la, input logic ld,
                     input logic re, input logic [2:0] ra, input logic rd);
    @(negedge clk);
    if (le) begin lt_sel_n = 1'b0; lt_rw = 1'b0; lt_addr = la; lt_wbit = ld; end
    if (re) begin rt_sel_n = 1'b0; rt_rw = 1'b0; rt_addr = ra; rt_wbit = rd; end
    @(negedge clk);
    lt_rw = 1'b1;
    rt_rw = 1'b1;
    @(negedge clk);
    lt_sel_n = 1'b1;
    rt_sel_n = 1'b1;
  endtask

  task automatic wl(input logic [2:0] a, input logic d);
    wr2(1'b1, a, d, 1'b0, 3'd0, 1'b0);
  endtask

  task automatic wr(input logic [2:0] a, input logic d);
    wr2(1'b0, 3'd0, 1'b0, 1'b1, a, d);
  endtask

  // side 0 = left, 1 = right; expected lanes follow R8.
  task automatic rd_chk(input int side, input logic [2:0] a, input logic [1:0] be,
                        input logic expb, input string tag);
    logic [1:0] e_en;
    logic [19:0] got, exp;
    @(negedge clk);
    if (side == 0) begin lt_sel_n = 1'b0; lt_oe_n = 1'b0; lt_addr = a; lt_be_n = be; end
    else           begin rt_sel_n = 1'b0; rt_oe_n = 1'b0; rt_addr = a; rt_be_n = be; end
    #1;
    e_en = ~be;
    exp  = {e_en, (e_en[1] ? {9{expb}} : 9'h0), (e_en[0] ? {9{expb}} : 9'h0)};
    got  = (side == 0) ? {lt_q_en, lt_q_hi, lt_q_lo} : {rt_q_en, rt_q_hi, rt_q_lo};
    check(tag, got, exp);
    lt_sel_n = 1'b1; lt_oe_n = 1'b1; lt_be_n = 2'b11;
    rt_sel_n = 1'b1; rt_oe_n = 1'b1; rt_be_n = 2'b11;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    lt_sel_n = 1'b1; lt_mem_en_n = 1'b1; lt_rw = 1'b1; lt_oe_n = 1'b1;
    lt_addr = '0; lt_wbit = 1'b0; lt_be_n = 2'b11;
    rt_sel_n = 1'b1; rt_mem_en_n = 1'b1; rt_rw = 1'b1; rt_oe_n = 1'b1;
    rt_addr = '0; rt_wbit = 1'b0; rt_be_n = 2'b11;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: everything free after reset
    for (int a = 0; a < 8; a++) begin
      rd_chk(0, 3'(a), 2'b00, 1'b1, "R1 left reset");
      rd_chk(1, 3'(a), 2'b00, 1'b1, "R1 right reset");
    end

    // R4 R5 R6 R9: claim, contend, hand off, release on every flag
    for (int k = 0; k < 8; k++) begin
      wl(3'(k), 1'b0);
      rd_chk(0, 3'(k), 2'b00, 1'b0, "R4 left owns");
      rd_chk(1, 3'(k), 2'b00, 1'b1, "R4 right sees taken");
      rd_chk(0, 3'(k + 1), 2'b00, 1'b1, "R9 neighbour untouched");
      wr(3'(k), 1'b0);
      rd_chk(1, 3'(k), 2'b00, 1'b1, "R5 right pending");
      wl(3'(k), 1'b1);
      rd_chk(1, 3'(k), 2'b00, 1'b0, "R6 right granted on release");
      rd_chk(0, 3'(k), 2'b00, 1'b1, "R6 left released");
      wr(3'(k), 1'b1);
      rd_chk(1, 3'(k), 2'b00, 1'b1, "R6 right released");
    end

    // R7: simultaneous request on each free flag
    for (int k = 0; k < 8; k++) begin
      wr2(1'b1, 3'(k), 1'b0, 1'b1, 3'(k), 1'b0);
      rd_chk(0, 3'(k), 2'b00, 1'b0, "R7 left wins tie");
      rd_chk(1, 3'(k), 2'b00, 1'b1, "R7 right loses tie");
      wl(3'(k), 1'b1);
      rd_chk(1, 3'(k), 2'b00, 1'b0, "R7 right pending then granted");
      wr(3'(k), 1'b1);
    end

    // R9: different flags in the same cycle
    wr2(1'b1, 3'd1, 1'b0, 1'b1, 3'd2, 1'b0);
    rd_chk(0, 3'd1, 2'b00, 1'b0, "R9 left flag1");
    rd_chk(1, 3'd2, 2'b00, 1'b0, "R9 right flag2");
    wr2(1'b1, 3'd1, 1'b1, 1'b1, 3'd2, 1'b1);
    rd_chk(0, 3'd2, 2'b00, 1'b1, "R9 flag2 free");

    // R8: lane enables
    wl(3'd3, 1'b0);
    for (int b = 0; b < 4; b++) begin
      rd_chk(0, 3'd3, 2'(b), 1'b0, "R8 left lanes");
      rd_chk(1, 3'd3, 2'(b), 1'b1, "R8 right lanes");
    end
    @(negedge clk);
    lt_sel_n = 1'b0; lt_oe_n = 1'b1; lt_addr = 3'd3; lt_be_n = 2'b00;
    #1;
    check("R8 no drive with output enable high", {lt_q_en, lt_q_hi, lt_q_lo}, 20'h0);
    lt_sel_n = 1'b1; lt_be_n = 2'b11;
    wl(3'd3, 1'b1);

    // R10: pending request withdrawn
    wl(3'd4, 1'b0);
    wr(3'd4, 1'b0);
    wr(3'd4, 1'b1);
    wl(3'd4, 1'b1);
    rd_chk(1, 3'd4, 2'b00, 1'b1, "R10 withdrawn request not granted");
    rd_chk(0, 3'd4, 2'b00, 1'b1, "R10 flag free");
    wr(3'd4, 1'b0);
    rd_chk(1, 3'd4, 2'b00, 1'b0, "R10 fresh request granted");
    wr(3'd4, 1'b1);

    // R3: chip enable active together with select
    @(negedge clk);
    lt_mem_en_n = 1'b0; lt_sel_n = 1'b0; lt_rw = 1'b0; lt_addr = 3'd0; lt_wbit = 1'b0;
    @(negedge clk);
    lt_rw = 1'b1; lt_oe_n = 1'b0; lt_be_n = 2'b00;
    #1;
    check("R3 no drive when illegal", {lt_q_en, lt_q_hi, lt_q_lo}, 20'h0);
    @(negedge clk);
    lt_mem_en_n = 1'b1; lt_sel_n = 1'b1; lt_oe_n = 1'b1; lt_be_n = 2'b11;
    rd_chk(0, 3'd0, 2'b00, 1'b1, "R3 illegal request ignored");
    rd_chk(1, 3'd0, 2'b00, 1'b1, "R3 right still free");
    wl(3'd7, 1'b0);
    @(negedge clk);
    lt_mem_en_n = 1'b0; lt_sel_n = 1'b0; lt_rw = 1'b0; lt_addr = 3'd7; lt_wbit = 1'b1;
    @(negedge clk);
    lt_rw = 1'b1;
    @(negedge clk);
    lt_mem_en_n = 1'b1; lt_sel_n = 1'b1;
    rd_chk(0, 3'd7, 2'b00, 1'b0, "R3 illegal release ignored");
    wl(3'd7, 1'b1);

    // R2: strobe held high gives no commit
    @(negedge clk);
    lt_sel_n = 1'b0; lt_addr = 3'd5; lt_wbit = 1'b0;
    repeat (3) @(negedge clk);
    lt_sel_n = 1'b1;
    rd_chk(0, 3'd5, 2'b00, 1'b1, "R2 no edge no commit");
    wr(3'd5, 1'b0);
    rd_chk(1, 3'd5, 2'b00, 1'b0, "R2 right claims untouched flag");
    wr(3'd5, 1'b1);

    // R11: edges with select high
    @(negedge clk);
    lt_addr = 3'd6; lt_wbit = 1'b0; lt_rw = 1'b0;
    @(negedge clk);
    lt_rw = 1'b1; lt_oe_n = 1'b0; lt_be_n = 2'b00;
    #1;
    check("R11 no drive when deselected", {lt_q_en, lt_q_hi, lt_q_lo}, 20'h0);
    lt_oe_n = 1'b1; lt_be_n = 2'b11;
    rd_chk(0, 3'd6, 2'b00, 1'b1, "R11 deselected edge ignored");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule